// File: doc/BRIEF.md
# Dual Channel Disk I/O Decoder

This block sits between a host I/O bus and a two-channel disk controller. Every host access carries an address, a byte size (1, 2 or 4), a direction and write data. The block compares the address with five programmable windows: command and control registers for each of the two channels, and one shared bus-master register window. It then forwards the access to the correct channel and register group with an adjusted offset. Accesses that match no window, or that have an illegal size, are flagged as errors.

The decoder watches command writes so that it always knows whether the master or the slave drive is selected on each channel. When the selected drive is missing, the access is absorbed: reads complete with zero data and anything wider than one byte is flagged. Two enable inputs gate the block. One turns all I/O decoding off. The other drops bus-master writes while still letting bus-master reads through. Each window base is written through a small register port, and a write of zero leaves the old base unchanged.

Top module: `disk_io_decoder`

## Requirements
- R1: Windows are tested in a fixed priority: primary command (base select 0), primary control (1), secondary command (2), secondary control (3), bus-master (4). An address hits a window when base <= addr < base + span. The primary command span is CMD_SPAN << CMD_SHIFT, both control spans are CTL_SPAN, the secondary command span is CMD_SPAN and the bus-master span is BM_SPAN. The first window that hits is used.
- R2: The routed offset is addr - base. For the primary command window it is then shifted right by CMD_SHIFT. For the primary control window CTL_ADD is added. The secondary windows use the raw offset. Group encoding: 0 command, 1 control, 2 bus-master. Channel encoding: 0 primary, 1 secondary.
- R3: In the bus-master window, offsets below BM_SPLIT (8) go to channel 0 unchanged. Offsets of BM_SPLIT and above go to channel 1 with BM_SPLIT subtracted.
- R4: While io_enable is low, an access of legal size completes with no route, no zero-read, no error and no change to drive selection.
- R5: While bm_enable is low, a bus-master write completes with no route and no error. Bus-master reads are still routed.
- R6: A write of legal size to command offset 6 (the adjusted offset) sets that channel's selection to bit 4 of the write data: 0 is master, 1 is slave. That access already uses the new selection. Both channels select master after reset. sel_slave[c] shows channel c.
- R7: drv_present bit {chan, slave} tells whether a drive exists. A command or control access to an absent selected drive is not routed. A 1-byte read raises acc_zero, a 1-byte write is silently absorbed, and any other size raises acc_err.
- R8: An access size other than 1, 2 or 4 raises acc_err, whether or not I/O decoding is enabled. With io_enable high, an address in no window also raises acc_err.
- R9: base_we with base_sel 0..4 loads that window base from base_wdata, unless the value is zero, in which case the base is unchanged. All bases reset to zero.
- R10: For each request, acc_done and the routed fields are valid one cycle later, for one cycle. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_enable | input | 1 | I/O decode enable |
| bm_enable | input | 1 | Bus-master write enable |
| base_we | input | 1 | Window base write strobe |
| base_sel | input | 3 | Window selected for base write |
| base_wdata | input | ADDR_W | New base value |
| drv_present | input | 4 | Drive present, bit {chan, slave} |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Access address |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | DATA_W | Write data |
| rt_valid | output | 1 | Routed access strobe |
| rt_chan | output | 1 | Target channel |
| rt_group | output | 2 | Register group |
| rt_offset | output | OFS_W | Adjusted offset |
| rt_size | output | 3 | Access size |
| rt_write | output | 1 | Direction |
| rt_wdata | output | DATA_W | Write data |
| acc_done | output | 1 | Access completed |
| acc_zero | output | 1 | Read absorbed, data is zero |
| acc_err | output | 1 | Bad size or unmapped address |
| sel_slave | output | 2 | Per-channel slave selection |

## Verification
The bench runs every address from 0 to 0xFFF as a write followed by a read. It cycles through legal and illegal sizes, and the write data toggle bit 4. This exercises window edges, the shifted and offset-added primary offsets, and the bus-master split point, and it lets the selection snoop move both channels between master and slave. The sweep is repeated with bus-master writes disabled, with I/O decoding disabled, and with different drive-present masks. Together these separate gated writes from gated reads and absorbed accesses from routed ones. A last sweep moves the secondary windows on top of the primary command window and writes a zero base. That separates the priority order and the zero-ignore rule from a plain match.

// File: rtl/dcd_pkg.sv
// Shared types for the dual channel disk I/O decoder.
// Assumes five windows in a fixed priority order given by win_e.
package dcd_pkg;
    localparam int NUM_WIN = 5;

    typedef enum logic [2:0] {
        WIN_PCMD = 3'd0,
        WIN_PCTL = 3'd1,
        WIN_SCMD = 3'd2,
        WIN_SCTL = 3'd3,
        WIN_BM   = 3'd4
    } win_e;

    typedef enum logic [1:0] {
        GRP_CMD = 2'd0,
        GRP_CTL = 2'd1,
        GRP_BM  = 2'd2
    } grp_e;
endpackage

// File: rtl/dcd_base_regs.sv
// Window base registers: one per window, loaded through a shared write
// port. A zero value is ignored. Assumes base_sel values above 4 do nothing.
module dcd_base_regs
    import dcd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [2:0]                        sel,
    input  logic [ADDR_W-1:0]                 wdata,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]    bases
);
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_base
        // Load one base when addressed and the value is non-zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bases[g] <= '0;
            end else if (we && sel == 3'(g) && wdata != '0) begin
                bases[g] <= wdata;
            end
        end
    end
endmodule

// File: rtl/dcd_window_match.sv
// Compares an address with the five windows and picks the first hit in
// priority order. Returns the window and the raw offset from its base.
// Assumes base + span fits in ADDR_W+1 bits.
module dcd_window_match
    import dcd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CMD_SPAN  = 8,
    parameter int CTL_SPAN  = 4,
    parameter int BM_SPAN   = 16,
    parameter int CMD_SHIFT = 0
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] bases,
    output logic                           hit,
    output win_e                           win,
    output logic [ADDR_W-1:0]              raw_ofs
);
    localparam int PCMD_SPAN = CMD_SPAN << CMD_SHIFT;

    logic [NUM_WIN-1:0] hv;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        localparam int SPAN = (g == 0) ? PCMD_SPAN :
                              (g == 2) ? CMD_SPAN  :
                              (g == 4) ? BM_SPAN   : CTL_SPAN;
        logic [ADDR_W:0] lim;
        assign lim   = {1'b0, bases[g]} + (ADDR_W+1)'(SPAN);
        assign hv[g] = (addr >= bases[g]) && ({1'b0, addr} < lim);
    end

    // Priority pick: lowest index wins.
    always_comb begin
        hit = 1'b0;
        win = WIN_PCMD;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hv[i]) begin
                hit = 1'b1;
                win = win_e'(i);
            end
        end
    end

    // Offset of the address inside the chosen window.
    always_comb raw_ofs = addr - bases[win];
endmodule

// File: rtl/dcd_drive_sel.sv
// Tracks master/slave selection for each channel from snooped command
// writes. Assumes at most one update per cycle.
module dcd_drive_sel #(
    parameter int NUM_CHAN = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_en,
    input  logic                upd_chan,
    input  logic                upd_slave,
    output logic [NUM_CHAN-1:0] sel_slave
);
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        // Record the selection bit for channel c.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_slave[c] <= 1'b0;
            end else if (upd_en && upd_chan == 1'(c)) begin
                sel_slave[c] <= upd_slave;
            end
        end
    end
endmodule

// File: rtl/disk_io_decoder.sv
// Host-side address decoder for a two-channel disk controller.
// Matches each access against five windows, adjusts the offset, tracks
// drive selection and registers a routed access, a zero-read or an error
// one cycle after the request. Assumes BM_SPAN is at most 2*BM_SPLIT.
module disk_io_decoder
    import dcd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int OFS_W     = 8,
    parameter int CMD_SPAN  = 8,
    parameter int CTL_SPAN  = 4,
    parameter int BM_SPAN   = 16,
    parameter int CMD_SHIFT = 0,
    parameter int CTL_ADD   = 0,
    parameter int SEL_OFS   = 6,
    parameter int SEL_BIT   = 4,
    parameter int BM_SPLIT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_enable,
    input  logic              bm_enable,
    input  logic              base_we,
    input  logic [2:0]        base_sel,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic [3:0]        drv_present,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rt_valid,
    output logic              rt_chan,
    output logic [1:0]        rt_group,
    output logic [OFS_W-1:0]  rt_offset,
    output logic [2:0]        rt_size,
    output logic              rt_write,
    output logic [DATA_W-1:0] rt_wdata,
    output logic              acc_done,
    output logic              acc_zero,
    output logic              acc_err,
    output logic [1:0]        sel_slave
);
    logic [NUM_WIN-1:0][ADDR_W-1:0] bases;
    logic              hit;
    win_e              win;
    logic [ADDR_W-1:0] raw_ofs;
    logic [ADDR_W-1:0] adj_ofs;
    logic              chan;
    grp_e              grp;
    logic              size_ok;
    logic              snoop;
    logic              eff_slave;
    logic              present;
    logic              n_route, n_zero, n_err;

    dcd_base_regs #(.ADDR_W(ADDR_W)) u_bases (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (base_we),
        .sel   (base_sel),
        .wdata (base_wdata),
        .bases (bases)
    );

    dcd_window_match #(
        .ADDR_W    (ADDR_W),
        .CMD_SPAN  (CMD_SPAN),
        .CTL_SPAN  (CTL_SPAN),
        .BM_SPAN   (BM_SPAN),
        .CMD_SHIFT (CMD_SHIFT)
    ) u_match (
        .addr    (req_addr),
        .bases   (bases),
        .hit     (hit),
        .win     (win),
        .raw_ofs (raw_ofs)
    );

    // Map the window to channel, group and adjusted offset.
    always_comb begin
        chan    = 1'b0;
        grp     = GRP_CMD;
        adj_ofs = raw_ofs;
        case (win)
            WIN_PCMD: adj_ofs = raw_ofs >> CMD_SHIFT;
            WIN_PCTL: begin
                grp     = GRP_CTL;
                adj_ofs = raw_ofs + ADDR_W'(CTL_ADD);
            end
            WIN_SCMD: chan = 1'b1;
            WIN_SCTL: begin
                chan = 1'b1;
                grp  = GRP_CTL;
            end
            default: begin
                grp = GRP_BM;
                if (raw_ofs >= ADDR_W'(BM_SPLIT)) begin
                    chan    = 1'b1;
                    adj_ofs = raw_ofs - ADDR_W'(BM_SPLIT);
                end
            end
        endcase
    end

    // Legal access sizes are 1, 2 and 4 bytes.
    always_comb size_ok = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);

    // Selection snoop on command writes to the select offset.
    always_comb snoop = req_valid && req_write && size_ok && io_enable && hit &&
                        grp == GRP_CMD && adj_ofs == ADDR_W'(SEL_OFS);

    dcd_drive_sel #(.NUM_CHAN(2)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (snoop),
        .upd_chan  (chan),
        .upd_slave (req_wdata[SEL_BIT]),
        .sel_slave (sel_slave)
    );

    // Presence of the drive selected for this access, after any snoop.
    always_comb begin
        eff_slave = snoop ? req_wdata[SEL_BIT] : sel_slave[chan];
        present   = drv_present[{chan, eff_slave}];
    end

    // Classify the access into route, zero-read or error.
    always_comb begin
        n_route = 1'b0;
        n_zero  = 1'b0;
        n_err   = 1'b0;
        if (req_valid) begin
            if (!size_ok) begin
                n_err = 1'b1;
            end else if (!io_enable) begin
                n_route = 1'b0;
            end else if (!hit) begin
                n_err = 1'b1;
            end else if (grp == GRP_BM) begin
                n_route = !(req_write && !bm_enable);
            end else if (!present) begin
                n_err  = (req_size != 3'd1);
                n_zero = (req_size == 3'd1) && !req_write;
            end else begin
                n_route = 1'b1;
            end
        end
    end

    // Register the outcome for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_valid  <= 1'b0;
            rt_chan   <= 1'b0;
            rt_group  <= 2'd0;
            rt_offset <= '0;
            rt_size   <= 3'd0;
            rt_write  <= 1'b0;
            rt_wdata  <= '0;
            acc_done  <= 1'b0;
            acc_zero  <= 1'b0;
            acc_err   <= 1'b0;
        end else begin
            rt_valid <= n_route;
            acc_done <= req_valid;
            acc_zero <= n_zero;
            acc_err  <= n_err;
            if (n_route) begin
                rt_chan   <= chan;
                rt_group  <= grp;
                rt_offset <= OFS_W'(adj_ofs);
                rt_size   <= req_size;
                rt_write  <= req_write;
                rt_wdata  <= req_wdata;
            end
        end
    end
endmodule

// File: rtl/dcd_checker.sv
// Temporal checks on the decoder ports, bound into disk_io_decoder.
module dcd_checker #(
    parameter int OFS_W    = 8,
    parameter int BM_SPLIT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             io_enable,
    input logic             bm_enable,
    input logic             req_valid,
    input logic             req_write,
    input logic             rt_valid,
    input logic [1:0]       rt_group,
    input logic [OFS_W-1:0] rt_offset,
    input logic [2:0]       rt_size,
    input logic             acc_done,
    input logic             acc_zero,
    input logic             acc_err,
    input logic [1:0]       sel_slave
);
    assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> acc_done);
    assert_done_has_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> $past(req_valid));
    assert_io_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !io_enable) |=> (!rt_valid && !acc_zero));
    assert_io_off_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !io_enable |=> $stable(sel_slave));
    assert_bm_wr_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !bm_enable) |=> !(rt_valid && rt_group == 2'd2));
    assert_bm_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && rt_group == 2'd2) |-> (rt_offset < OFS_W'(BM_SPLIT)));
    assert_zero_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_zero |-> !$past(req_write));
    assert_err_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (!rt_valid && !acc_zero));
    assert_route_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid |-> (rt_size == 3'd1 || rt_size == 3'd2 || rt_size == 3'd4));
endmodule

bind disk_io_decoder dcd_checker #(.OFS_W(OFS_W), .BM_SPLIT(BM_SPLIT)) u_dcd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_enable (io_enable),
    .bm_enable (bm_enable),
    .req_valid (req_valid),
    .req_write (req_write),
    .rt_valid  (rt_valid),
    .rt_group  (rt_group),
    .rt_offset (rt_offset),
    .rt_size   (rt_size),
    .acc_done  (acc_done),
    .acc_zero  (acc_zero),
    .acc_err   (acc_err),
    .sel_slave (sel_slave)
);

// File: tb/test_disk_io_decoder.sv
// Sweeps the address space under several configurations and compares each
// access with an arithmetic model of the requirements.
module test_disk_io_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int OW = 8;
    localparam int SHIFT = 1;
    localparam int CADD = 2;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic io_enable = 1'b0, bm_enable = 1'b0;
    logic base_we = 1'b0;
    logic [2:0] base_sel = '0;
    logic [AW-1:0] base_wdata = '0;
    logic [3:0] drv_present = '0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0] req_size = '0;
    logic [DW-1:0] req_wdata = '0;
    logic rt_valid, rt_chan, rt_write, acc_done, acc_zero, acc_err;
    logic [1:0] rt_group, sel_slave;
    logic [OW-1:0] rt_offset;
    logic [2:0] rt_size;
    logic [DW-1:0] rt_wdata;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int m_base[5];
    bit m_sel[2];
    int spans[5] = '{16, 4, 8, 4, 16};

    always #(CLK_PERIOD/2) clk = ~clk;

    disk_io_decoder #(
        .ADDR_W(AW), .DATA_W(DW), .OFS_W(OW), .CMD_SHIFT(SHIFT), .CTL_ADD(CADD)
    ) i_disk_io_decoder (
        .clk(clk), .rst_n(rst_n), .io_enable(io_enable), .bm_enable(bm_enable),
        .base_we(base_we), .base_sel(base_sel), .base_wdata(base_wdata),
        .drv_present(drv_present), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rt_valid(rt_valid), .rt_chan(rt_chan), .rt_group(rt_group),
        .rt_offset(rt_offset), .rt_size(rt_size), .rt_write(rt_write),
        .rt_wdata(rt_wdata), .acc_done(acc_done), .acc_zero(acc_zero),
        .acc_err(acc_err), .sel_slave(sel_slave)
    );

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // R9: base write, zero ignored in the model
    task automatic set_base(int sel, int val);
        @(negedge clk);
        base_we = 1'b1; base_sel = 3'(sel); base_wdata = AW'(val);
        @(negedge clk);
        base_we = 1'b0;
        if (val != 0) m_base[sel] = val;
    endtask

    task automatic access(bit wr, int addr, int size, logic [DW-1:0] data);
        int win = -1;
        int ofs = 0, ch = 0, grp = 0;
        bit e_route = 0, e_zero = 0, e_err = 0;
        bit sz_ok = (size == 1 || size == 2 || size == 4);
        string tag = "R10";
        for (int i = 4; i >= 0; i--)
            if (addr >= m_base[i] && addr < m_base[i] + spans[i]) win = i;
        if (win >= 0) begin
            ofs = addr - m_base[win];
            case (win)
                0: begin ofs = ofs >> SHIFT; tag = "R2"; end
                1: begin ofs = ofs + CADD; grp = 1; tag = "R2"; end
                2: begin ch = 1; tag = "R1"; end
                3: begin ch = 1; grp = 1; tag = "R1"; end
                default: begin
                    grp = 2; tag = "R3";
                    if (ofs >= 8) begin ch = 1; ofs = ofs - 8; end
                end
            endcase
        end
        if (!sz_ok) begin e_err = 1; tag = "R8"; end
        else if (!io_enable) tag = "R4";
        else if (win < 0) begin e_err = 1; tag = "R8"; end
        else if (grp == 2) begin
            e_route = !(wr && !bm_enable);
            if (wr && !bm_enable) tag = "R5";
        end else begin
            if (wr && grp == 0 && ofs == 6) begin m_sel[ch] = data[4]; tag = "R6"; end
            if (!drv_present[ch*2 + int'(m_sel[ch])]) begin
                tag = "R7";
                e_err = (size != 1);
                e_zero = (size == 1) && !wr;
            end else e_route = 1;
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(addr);
        req_size = 3'(size); req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        if (e_route)
            check(tag, {rt_valid, acc_done, acc_zero, acc_err, sel_slave, rt_chan, rt_group,
                        rt_offset, rt_size, rt_write, rt_wdata},
                  {1'b1, 1'b1, 1'b0, 1'b0, m_sel[1], m_sel[0], 1'(ch), 2'(grp),
                   OW'(ofs), 3'(size), wr, data});
        else
            check(tag, {rt_valid, acc_done, acc_zero, acc_err, sel_slave},
                  {1'b0, 1'b1, e_zero, e_err, m_sel[1], m_sel[0]});
    endtask

    task automatic sweep(int ph);
        int sizes[4] = '{1, 2, 4, 3};
        for (int a = 0; a < 4096; a++) begin
            logic [DW-1:0] d = {16'hC0DE, 16'(a)} ^ DW'((ph & 1) << 4);
            access(1'b1, a, sizes[(a + ph) % 4], d);
            access(1'b0, a, sizes[(a + ph + 1) % 4], d);
        end
    endtask

    initial begin
        for (int i = 0; i < 5; i++) m_base[i] = 0;
        m_sel[0] = 0; m_sel[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10, R6: reset state of outputs and selection
        check("R10", {rt_valid, acc_done, acc_zero, acc_err, sel_slave}, 6'b0);
        set_base(0, 16'h01F0);
        set_base(1, 16'h03F6);
        set_base(2, 16'h0170);
        set_base(3, 16'h0376);
        set_base(4, 16'h0C00);
        io_enable = 1; bm_enable = 1; drv_present = 4'b1101;
        sweep(0);
        bm_enable = 0; drv_present = 4'b0111;
        sweep(1);
        io_enable = 0; bm_enable = 1; drv_present = 4'b1111;
        sweep(2);
        // R1 priority with overlapping windows, R9 zero base ignored
        set_base(2, 16'h01F8);
        set_base(3, 16'h01FC);
        set_base(4, 0);
        io_enable = 1; drv_present = 4'b1011;
        sweep(3);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R10 got=hung exp=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule